// File: doc/BRIEF.md
# Cascadable Codec Serial Port Node

This block is the serial interface of one codec device that sits in a daisy chain of identical devices between a host controller and the last node. Words are 16 bits wide. Each word is framed by a one-clock frame-sync pulse, and the bits follow MSB first, one per serial clock. A sample-event strobe loads the local ADC word into the transmit path and sends it toward the host behind an output frame sync. The host drives words into the head of the chain, and every node either consumes a word or passes it on. Because the routing rules are the same in every node, all nodes in the chain act on their own word on the same clock.

The node has two modes. In program mode, an incoming word with its control flag set is routed by a device address. When that address is zero, the node applies the word to one of its own registers. When it is nonzero, the node decrements the address and passes the word on. A word without the control flag is relayed untouched. In data mode, every incoming word is a DAC word and the node counts frames. The frame that brings the count up to the programmed chain length is latched into the DAC register. Every earlier frame is relayed, and the counter then starts again from zero. Analog conversion, clock generation and the host are outside this block. The clock-divider settings are only presented as outputs.

Top module: `cscn_node`

## Requirements
- R1: After reset the node is in program mode, the chain length field reads 1, the divider outputs read 0, the DAC word is 0, and fs_out, sd_out and dac_strobe are low.
- R2: A sample_evt strobe sampled at a clock edge makes fs_out high in the following cycle. The 16 bits of adc_word then appear on sd_out, MSB first, one per cycle over the next 16 cycles.
- R3: In program mode, a word with bit 15 = 1 (control), bit 14 = 1 (write) and device address bits 13:11 = 0 writes data bits 7:0 to the register selected by bits 10:8. Register 0 is control A: bit 0 = data mode, bits 3:1 = chain length. Register 1 is control B: bits 2:0 = master clock divider, bits 4:3 = serial rate select, where 0 means divide by 8, 1 by 4, 2 by 2 and 3 by 1. A write is not forwarded, and the mode bit, once set, stays set until reset.
- R4: A control read (bit 14 = 0) with device address 0 is answered downstream with bits 15:8 kept, the address field 0 and bits 7:0 replaced by the selected register, which reads 0 for register numbers 2 to 7.
- R5: In program mode, a control word with a nonzero device address is forwarded with that field decremented by one and every other bit unchanged.
- R6: In program mode, a word with bit 15 = 0 is forwarded unchanged.
- R7: Writes to register numbers 2 to 7 change neither control register.
- R8: In data mode, each received word counts one frame. A frame that does not complete the count is forwarded unchanged, whatever its bit 15, and dac_strobe stays low.
- R9: In data mode, the frame that brings the count to the chain length loads dac_word with that word and pulses dac_strobe for one cycle. That frame is not forwarded, and the count returns to zero. dac_word changes only with dac_strobe.
- R10: A chain length field of 0 means a chain of 8 devices.
- R11: For a forwarded word, fs_out is high in the second cycle after the cycle that carried the last input bit, and sd_out is low while fs_out is high.
- R12: If a sample event and a forward fall in the same cycle, the ADC word is sent and the forwarded word is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_in | input | 1 | Input frame sync, one cycle before the MSB |
| sd_in | input | 1 | Serial data in, MSB first |
| sample_evt | input | 1 | ADC sample event strobe |
| adc_word | input | 16 | Local ADC word, captured on sample_evt |
| fs_out | output | 1 | Output frame sync toward the host |
| sd_out | output | 1 | Serial data out, MSB first |
| dac_word | output | 16 | Latched DAC word |
| dac_strobe | output | 1 | One-cycle pulse when dac_word updates |
| data_mode | output | 1 | High once data mode is entered |
| chain_len | output | 3 | Programmed chain length field (0 means 8) |
| mclk_div | output | 3 | Master clock divider setting |
| sclk_sel | output | 2 | Serial clock rate select |

## Verification
The properties assume that reset is applied before the first frame. They also assume that an input frame sync never arrives while a word is still being shifted in, since a late sync restarts the bit count. The stimulus meets both conditions by holding reset low at the start and by sending each frame as exactly one sync pulse followed by 16 bits. No new frame starts until the previous one has been fully handled. The only deliberate overlap is a sample strobe placed in the same cycle as a forward, which is used to exercise the priority rule.

// File: rtl/cscn_pkg.sv
package cscn_pkg;
    localparam int WORD_W    = 16;
    // control word layout
    localparam int CTRL_POS  = 15;
    localparam int RW_POS    = 14;
    localparam int DEV_LSB   = 11;
    localparam int DEV_W     = 3;
    localparam int REG_LSB   = 8;
    localparam int REG_W     = 3;
    localparam int DATA_W    = 8;
    // control A fields
    localparam int A_MODE    = 0;
    localparam int LEN_LSB   = 1;
    localparam int LEN_W     = 3;
    // control B fields
    localparam int MCLK_LSB  = 0;
    localparam int MCLK_W    = 3;
    localparam int SCLK_LSB  = 3;
    localparam int SCLK_W    = 2;
    localparam int CNT_W     = LEN_W + 1;
    localparam logic [DATA_W-1:0] CTRL_A_RST = DATA_W'(1 << LEN_LSB);
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cscn_rx.sv
module cscn_rx
    import cscn_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fs_in,
    input  logic         sd_in,
    output logic [W-1:0] word_o,
    output logic         done_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] left;
        logic          done;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.left != '0) begin
            st_d.sr   = {st_q.sr[W-2:0], sd_in};
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == CW'(1)) st_d.done = 1'b1;
        end
        if (fs_in) st_d.left = CW'(W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.sr;
    assign done_o = st_q.done;
endmodule

// File: rtl/cscn_tx.sv
module cscn_tx
    import cscn_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic         fs_out,
    output logic         sd_out
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] left;
        logic          fs;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   shifting;

    assign shifting = (st_q.left != '0) && !st_q.fs;

    always_comb begin
        st_d    = st_q;
        st_d.fs = 1'b0;
        if (shifting) begin
            st_d.sr   = {st_q.sr[W-2:0], 1'b0};
            st_d.left = st_q.left - 1'b1;
        end
        if (load_i) begin
            st_d.sr   = word_i;
            st_d.left = CW'(W);
            st_d.fs   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fs_out = st_q.fs;
    assign sd_out = shifting ? st_q.sr[W-1] : 1'b0;
endmodule

// File: rtl/cscn_router.sv
module cscn_router
    import cscn_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic [W-1:0]      adc_i,
    input  logic              done_i,
    input  logic [W-1:0]      word_i,
    output logic              load_o,
    output logic [W-1:0]      word_o,
    output logic [W-1:0]      dac_o,
    output logic              strobe_o,
    output logic              mode_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [MCLK_W-1:0] mclk_o,
    output logic [SCLK_W-1:0] sclk_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl_a;
        logic [DATA_W-1:0] ctrl_b;
        logic [CNT_W-1:0]  cnt;
        logic [W-1:0]      dac;
        logic              strobe;
    } rt_st_t;

    rt_st_t            st_d, st_q;
    logic              fwd;
    logic [W-1:0]      fwd_word;
    logic [CNT_W-1:0]  len_full;
    logic [LEN_W-1:0]  len_fld;
    logic [DEV_W-1:0]  dev;
    logic [REG_W-1:0]  rsel;
    logic [DATA_W-1:0] rd_val;

    assign len_fld  = st_q.ctrl_a[LEN_LSB +: LEN_W];
    assign len_full = (len_fld == '0) ? CNT_W'(1 << LEN_W) : CNT_W'(len_fld);
    assign dev      = word_i[DEV_LSB +: DEV_W];
    assign rsel     = word_i[REG_LSB +: REG_W];

    always_comb begin
        case (rsel)
            REG_W'(0): rd_val = st_q.ctrl_a;
            REG_W'(1): rd_val = st_q.ctrl_b;
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        fwd         = 1'b0;
        fwd_word    = word_i;
        if (done_i) begin
            if (st_q.ctrl_a[A_MODE]) begin
                if (st_q.cnt + CNT_W'(1) == len_full) begin
                    st_d.dac    = word_i;
                    st_d.strobe = 1'b1;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                    fwd      = 1'b1;
                end
            end else if (word_i[CTRL_POS]) begin
                if (dev == '0) begin
                    if (word_i[RW_POS]) begin
                        if (rsel == REG_W'(0)) st_d.ctrl_a = word_i[DATA_W-1:0];
                        if (rsel == REG_W'(1)) st_d.ctrl_b = word_i[DATA_W-1:0];
                    end else begin
                        fwd                    = 1'b1;
                        fwd_word[DATA_W-1:0]   = rd_val;
                    end
                end else begin
                    fwd                        = 1'b1;
                    fwd_word[DEV_LSB +: DEV_W] = dev - 1'b1;
                end
            end else begin
                fwd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ctrl_a <= CTRL_A_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o   = sample_i | fwd;
    assign word_o   = sample_i ? adc_i : fwd_word;
    assign dac_o    = st_q.dac;
    assign strobe_o = st_q.strobe;
    assign mode_o   = st_q.ctrl_a[A_MODE];
    assign len_o    = len_fld;
    assign mclk_o   = st_q.ctrl_b[MCLK_LSB +: MCLK_W];
    assign sclk_o   = st_q.ctrl_b[SCLK_LSB +: SCLK_W];
endmodule

// File: rtl/cscn_node.sv
module cscn_node
    import cscn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_in,
    input  logic              sd_in,
    input  logic              sample_evt,
    input  logic [WORD_W-1:0] adc_word,
    output logic              fs_out,
    output logic              sd_out,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_strobe,
    output logic              data_mode,
    output logic [LEN_W-1:0]  chain_len,
    output logic [MCLK_W-1:0] mclk_div,
    output logic [SCLK_W-1:0] sclk_sel
);
    word_t rx_word, tx_word;
    logic  rx_done, tx_load;

    cscn_rx #(.W(WORD_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .fs_in  (fs_in),
        .sd_in  (sd_in),
        .word_o (rx_word),
        .done_o (rx_done)
    );

    cscn_router #(.W(WORD_W)) u_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_evt),
        .adc_i    (adc_word),
        .done_i   (rx_done),
        .word_i   (rx_word),
        .load_o   (tx_load),
        .word_o   (tx_word),
        .dac_o    (dac_word),
        .strobe_o (dac_strobe),
        .mode_o   (data_mode),
        .len_o    (chain_len),
        .mclk_o   (mclk_div),
        .sclk_o   (sclk_sel)
    );

    cscn_tx #(.W(WORD_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tx_load),
        .word_i (tx_word),
        .fs_out (fs_out),
        .sd_out (sd_out)
    );
endmodule

// File: rtl/cscn_node_chk.sv
module cscn_node_chk
    import cscn_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sample_evt,
    input logic              fs_out,
    input logic              sd_out,
    input logic [WORD_W-1:0] dac_word,
    input logic              dac_strobe,
    input logic              data_mode
);
    assert_sample_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_evt |=> fs_out);

    assert_sync_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |-> !sd_out);

    assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_mode |=> data_mode);

    assert_strobe_in_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |-> data_mode);

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |=> !dac_strobe);

    assert_dac_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |-> dac_strobe);
endmodule

bind cscn_node cscn_node_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_evt (sample_evt),
    .fs_out     (fs_out),
    .sd_out     (sd_out),
    .dac_word   (dac_word),
    .dac_strobe (dac_strobe),
    .data_mode  (data_mode)
);

// File: tb/cscn_node_tb.sv
`timescale 1ns/1ps
module cscn_node_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs_in = 1'b0, sd_in = 1'b0, sample_evt = 1'b0;
    logic [15:0] adc_word = '0;
    logic        fs_out, sd_out, dac_strobe, data_mode;
    logic [15:0] dac_word;
    logic [2:0]  chain_len, mclk_div;
    logic [1:0]  sclk_sel;
    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cscn_node u_dut (
        .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .sd_in(sd_in),
        .sample_evt(sample_evt), .adc_word(adc_word), .fs_out(fs_out),
        .sd_out(sd_out), .dac_word(dac_word), .dac_strobe(dac_strobe),
        .data_mode(data_mode), .chain_len(chain_len), .mclk_div(mclk_div),
        .sclk_sel(sclk_sel)
    );

    // {forwarded, input word, expected output word}
    localparam logic [32:0] VEC [9] = '{
        {1'b1, 16'h1234, 16'h1234},  // R6 plain word relayed
        {1'b1, 16'hD9AA, 16'hD1AA},  // R5 address 3 -> 2
        {1'b1, 16'h8055, 16'h8002},  // R4 read control A
        {1'b0, 16'hC11D, 16'h0000},  // R3 write control B
        {1'b1, 16'h8100, 16'h811D},  // R4 read control B
        {1'b0, 16'hC6FF, 16'h0000},  // R7 write to register 6
        {1'b1, 16'h8600, 16'h8600},  // R7 register 6 reads 0
        {1'b1, 16'h8833, 16'h8033},  // R5 address 1 -> 0
        {1'b1, 16'h8000, 16'h8002}   // R7 control A unchanged
    };
    localparam string TAG [9] = '{"R6", "R5", "R4", "R3", "R4", "R7", "R7", "R5", "R7"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [15:0] w);
        @(negedge clk); fs_in = 1'b1; sd_in = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); fs_in = 1'b0; sd_in = w[i];
        end
    endtask

    task automatic end_frame(input logic smp, input logic [15:0] adc);
        @(negedge clk); sd_in = 1'b0; sample_evt = smp; adc_word = adc;
    endtask

    task automatic get_out(input int max_wait, output int at, output logic [15:0] w);
        at = 0; w = '0;
        for (int k = 1; k <= max_wait; k++) begin
            @(negedge clk); sample_evt = 1'b0;
            if (fs_out) begin
                at = k;
                break;
            end
        end
        if (at != 0)
            for (int b = 15; b >= 0; b--) begin
                @(negedge clk); w[b] = sd_out;
            end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int          at;
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 data_mode", data_mode, 0);
        chk("R1 chain_len", chain_len, 1);
        chk("R1 mclk_div", mclk_div, 0);
        chk("R1 sclk_sel", sclk_sel, 0);
        chk("R1 dac_word", dac_word, 0);
        chk("R1 outputs idle", {fs_out, sd_out, dac_strobe}, 0);

        // R2 sample event
        @(negedge clk); sample_evt = 1'b1; adc_word = 16'hA5C3;
        get_out(4, at, w);
        chk("R2 fs timing", at, 1);
        chk("R2 adc word", w, 16'hA5C3);

        for (int i = 0; i < 9; i++) begin
            send_frame(VEC[i][31:16]);
            end_frame(1'b0, 16'h0);
            if (VEC[i][32]) begin
                get_out(4, at, w);
                chk({TAG[i], " R11 fs timing"}, at, 1);
                chk({TAG[i], " forwarded word"}, w, {16'h0, VEC[i][15:0]});
            end else begin
                get_out(20, at, w);
                chk({TAG[i], " consumed, no forward"}, at, 0);
            end
        end
        chk("R3 mclk_div", mclk_div, 5);
        chk("R3 sclk_sel", sclk_sel, 3);

        // R12 sample event wins over forward
        send_frame(16'h1234);
        end_frame(1'b1, 16'h0F0F);
        get_out(4, at, w);
        chk("R12 sample timing", at, 1);
        chk("R12 adc word sent", w, 16'h0F0F);
        get_out(25, at, w);
        chk("R12 forward dropped", at, 0);

        // enter data mode, chain of 2
        send_frame(16'hC005);
        end_frame(1'b0, 16'h0);
        get_out(20, at, w);
        chk("R3 write not forwarded", at, 0);
        chk("R3 data_mode set", data_mode, 1);
        chk("R3 chain_len", chain_len, 2);

        for (int r = 0; r < 2; r++) begin
            logic [15:0] first_w, last_w;
            first_w = (r == 0) ? 16'hBEEF : 16'hC123;
            last_w  = (r == 0) ? 16'h1357 : 16'h4444;
            send_frame(first_w);
            end_frame(1'b0, 16'h0);
            get_out(4, at, w);
            chk("R8 relay timing", at, 1);
            chk("R8 relayed word", w, first_w);
            chk("R8 dac unchanged", dac_word, (r == 0) ? 16'h0 : 16'h1357);
            send_frame(last_w);
            end_frame(1'b0, 16'h0);
            @(negedge clk);
            chk("R9 strobe", dac_strobe, 1);
            chk("R9 dac_word", dac_word, last_w);
            get_out(20, at, w);
            chk("R9 not forwarded", at, 0);
            chk("R9 strobe single", dac_strobe, 0);
        end
        chk("R3 mode still set", data_mode, 1);

        // R10 length field 0 means 8
        do_reset();
        @(negedge clk);
        chk("R1 mode cleared by reset", data_mode, 0);
        send_frame(16'hC001);
        end_frame(1'b0, 16'h0);
        get_out(20, at, w);
        chk("R10 chain_len field", chain_len, 0);
        for (int i = 0; i < 7; i++) begin
            send_frame(16'h0100 + 16'(i));
            end_frame(1'b0, 16'h0);
            get_out(4, at, w);
            chk("R10 frames 1..7 relayed", at, 1);
            chk("R10 relayed word", w, 16'h0100 + 16'(i));
        end
        send_frame(16'h7788);
        end_frame(1'b0, 16'h0);
        @(negedge clk);
        chk("R10 strobe on eighth", dac_strobe, 1);
        chk("R10 dac word", dac_word, 16'h7788);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule